// File: doc/BRIEF.md
# Fail-Safe Clock Monitor with Glitch-Free Switchover

This block supervises an external primary clock. It uses an always-running internal oscillator as the reference. The internal clock is divided into a slow sample period of `DIV` internal cycles. Each time the sample clock rises, a monitor flag is armed. Any falling edge of the primary clock clears the flag. If the flag is still armed when the sample clock falls, the primary clock is declared failed.

When a failure is declared, the block does three things:
- It latches an oscillator-fail interrupt flag.
- It moves the system clock to the internal oscillator through a glitch-free multiplexer.
- It pulses a reset for one cycle to the external watchdog and its postscaler.

The ready status is deliberately left as it was, so software still sees the primary source as selected. The block stays in this fail-safe state until a reset or a power-mode entry.

The block also controls start-up. After reset, the system runs on the internal clock until the oscillator-ready input arrives. The block then hands over to the primary clock and sets the ready status. Monitoring runs only while the primary clock is selected and the enable input is high. The internal oscillator itself is not supervised.

Top module: `fscm_top`

## Requirements
- R1: After reset, `clk_sys` follows `clk_int`, and `pri_ready`, `fail_irq` and `wdt_rst` are 0.
- R2: After `osc_ready` has been high for a few internal cycles, `pri_ready` becomes 1. Within a few primary cycles after that, `clk_sys` follows `clk_pri`.
- R3: While `osc_ready` stays low, the system stays on `clk_int` indefinitely. No failure is declared even if `clk_pri` is stopped.
- R4: The sample period is `DIV` (64) internal cycles. A running primary clock whose period is longer than two internal periods never causes a failure. A primary clock that stops, stuck low or stuck high, is declared failed within 2*DIV+8 internal cycles.
- R5: With `mon_en` low, a stopped primary clock is never declared failed.
- R6: On a failure, `fail_irq` becomes 1 and stays 1. `clk_sys` then follows `clk_int`, even when the primary clock is stuck high.
- R7: Each failure produces exactly one `wdt_rst` pulse, one internal cycle wide.
- R8: In the fail-safe state, `pri_ready` stays 1, which is its value from before the failure.
- R9: The fail-safe state survives the primary clock restarting. It ends only on reset or on a `pm_entry` pulse. `pm_entry` clears `pri_ready` and returns to start-up. Once `osc_ready` has been high again, the block switches to the primary clock and monitoring resumes, so a new failure gives a new `wdt_rst` pulse.
- R10: The two clock enables of the multiplexer are never both active.
- R11: `fail_irq` is not cleared by `pm_entry`. Only reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_int | input | 1 | Internal reference oscillator; clocks the control logic |
| clk_pri | input | 1 | External primary clock being monitored |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_en | input | 1 | Configuration enable for failure monitoring |
| osc_ready | input | 1 | Primary oscillator ready (asynchronous) |
| pm_entry | input | 1 | One-cycle pulse on `clk_int` marking power-mode entry |
| clk_sys | output | 1 | Selected system clock |
| fail_irq | output | 1 | Sticky oscillator-fail interrupt flag |
| wdt_rst | output | 1 | One-cycle watchdog and postscaler reset pulse |
| pri_ready | output | 1 | Status: primary clock selected after start-up |

## Verification
A monitor flag stuck at the wrong value shows at the ports in one of two ways. A flag stuck armed gives a false `fail_irq` and a `wdt_rst` pulse at the first sample falling edge, about one sample period after the switch to the primary clock. A flag never armed leaves `clk_sys` frozen after the primary clock stops, with no interrupt ever raised. A wrong mode state shows within a few cycles as `pri_ready` changing, or failing to change, at the `osc_ready` or `pm_entry` edges. A wrong multiplexer enable shows at once in the count of `clk_sys` edges over a fixed window, compared with either source clock.

// File: rtl/fscm_pkg.sv
`timescale 1ns/1ps
package fscm_pkg;
  typedef enum logic [1:0] {
    ST_BOOT = 2'd0,
    ST_PRI  = 2'd1,
    ST_SAFE = 2'd2
  } mode_e;

  // wrap-around step of the sample divider
  function automatic int next_count(int c, int div);
    return (c >= div - 1) ? 0 : c + 1;
  endfunction

  // worst-case detection latency in internal cycles
  function automatic int fail_bound(int div);
    return 2 * div + 8;
  endfunction
endpackage

// File: rtl/fscm_divider.sv
`timescale 1ns/1ps
module fscm_divider #(
  parameter int DIV = 64
) (
  input  logic clk,
  input  logic rst_n,
  output logic samp_rise,
  output logic samp_fall
);
  localparam int CW   = $clog2(DIV);
  localparam int HALF = DIV / 2;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= CW'(fscm_pkg::next_count(int'(cnt), DIV));
  end

  // sample clock is high while cnt is in the upper half
  assign samp_rise = (cnt == CW'(HALF - 1));
  assign samp_fall = (cnt == CW'(DIV - 1));
endmodule

// File: rtl/fscm_detector.sv
`timescale 1ns/1ps
module fscm_detector (
  input  logic clk_int,
  input  logic clk_pri,
  input  logic rst_n,
  input  logic active,
  input  logic samp_rise,
  input  logic samp_fall,
  output logic fail_evt
);
  logic       pri_tog;
  logic [2:0] tog_s;
  logic       pri_edge;
  logic       armed;

  // falling edges of the primary clock toggle a flag
  always_ff @(negedge clk_pri or negedge rst_n) begin
    if (!rst_n) pri_tog <= 1'b0;
    else        pri_tog <= ~pri_tog;
  end

  always_ff @(posedge clk_int or negedge rst_n) begin
    if (!rst_n) tog_s <= '0;
    else        tog_s <= {tog_s[1:0], pri_tog};
  end

  assign pri_edge = tog_s[2] ^ tog_s[1];

  // monitor flag: armed by sample rise, cleared by a primary edge
  always_ff @(posedge clk_int or negedge rst_n) begin
    if (!rst_n)         armed <= 1'b0;
    else if (!active)   armed <= 1'b0;
    else if (samp_rise) armed <= 1'b1;
    else if (pri_edge)  armed <= 1'b0;
  end

  assign fail_evt = active & samp_fall & armed;

  // R4
  no_edge_fail_chk: assert property (@(posedge clk_int) disable iff (!rst_n)
    fail_evt |-> !$past(pri_edge));
endmodule

// File: rtl/fscm_ctrl.sv
`timescale 1ns/1ps
module fscm_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_ready,
  input  logic pm_entry,
  input  logic mon_en,
  input  logic fail_evt,
  output logic want_pri,
  output logic active,
  output logic pri_ready,
  output logic fail_irq,
  output logic wdt_rst
);
  import fscm_pkg::*;

  mode_e      mode;
  logic [1:0] rdy_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode      <= ST_BOOT;
      rdy_s     <= '0;
      pri_ready <= 1'b0;
      fail_irq  <= 1'b0;
      wdt_rst   <= 1'b0;
    end else begin
      rdy_s   <= {rdy_s[0], osc_ready};
      wdt_rst <= 1'b0;
      unique case (mode)
        ST_BOOT: if (rdy_s[1]) begin
          mode      <= ST_PRI;
          pri_ready <= 1'b1;
        end
        ST_PRI: if (fail_evt) begin
          mode     <= ST_SAFE;
          fail_irq <= 1'b1;
          wdt_rst  <= 1'b1;
        end
        ST_SAFE: if (pm_entry) begin
          mode      <= ST_BOOT;
          pri_ready <= 1'b0;
        end
        default: mode <= ST_BOOT;
      endcase
    end
  end

  assign want_pri = (mode == ST_PRI);
  assign active   = mon_en && (mode == ST_PRI);

  // R7
  wdt_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |=> !wdt_rst);
  // R6
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail_irq |=> fail_irq);
  // R8
  ready_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_irq) |-> pri_ready);
  // R7
  wdt_with_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |-> fail_irq);
  // R9
  safe_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == ST_SAFE && !pm_entry) |=> (mode == ST_SAFE));
endmodule

// File: rtl/fscm_clkmux.sv
`timescale 1ns/1ps
module fscm_clkmux (
  input  logic clk_int,
  input  logic clk_pri,
  input  logic rst_n,
  input  logic want_pri,
  output logic clk_sys
);
  logic       kill_pri;
  logic [1:0] ps;
  logic [1:0] is;
  logic       en_pri;
  logic       en_int;

  // primary side is cleared at once when not wanted: it may be dead
  assign kill_pri = !rst_n || !want_pri;

  always_ff @(posedge clk_pri or posedge kill_pri) begin
    if (kill_pri) ps <= '0;
    else          ps <= {ps[0], ~en_int};
  end

  always_ff @(negedge clk_pri or posedge kill_pri) begin
    if (kill_pri) en_pri <= 1'b0;
    else          en_pri <= ps[1];
  end

  always_ff @(posedge clk_int or negedge rst_n) begin
    if (!rst_n) is <= 2'b11;
    else        is <= {is[0], ~want_pri & ~en_pri};
  end

  always_ff @(negedge clk_int or negedge rst_n) begin
    if (!rst_n) en_int <= 1'b1;
    else        en_int <= is[1];
  end

  assign clk_sys = (clk_pri & en_pri) | (clk_int & en_int);

  // R10
  always_comb begin
    if (rst_n) mux_excl_chk: assert (!(en_pri && en_int));
  end
endmodule

// File: rtl/fscm_top.sv
`timescale 1ns/1ps
module fscm_top #(
  parameter int DIV = 64
) (
  input  logic clk_int,
  input  logic clk_pri,
  input  logic rst_n,
  input  logic mon_en,
  input  logic osc_ready,
  input  logic pm_entry,
  output logic clk_sys,
  output logic fail_irq,
  output logic wdt_rst,
  output logic pri_ready
);
  logic samp_rise, samp_fall, fail_evt, want_pri, active;

  fscm_divider #(.DIV(DIV)) u_div (
    .clk(clk_int), .rst_n(rst_n), .samp_rise(samp_rise), .samp_fall(samp_fall)
  );

  fscm_detector u_det (
    .clk_int(clk_int), .clk_pri(clk_pri), .rst_n(rst_n), .active(active),
    .samp_rise(samp_rise), .samp_fall(samp_fall), .fail_evt(fail_evt)
  );

  fscm_ctrl u_ctrl (
    .clk(clk_int), .rst_n(rst_n), .osc_ready(osc_ready), .pm_entry(pm_entry),
    .mon_en(mon_en), .fail_evt(fail_evt), .want_pri(want_pri), .active(active),
    .pri_ready(pri_ready), .fail_irq(fail_irq), .wdt_rst(wdt_rst)
  );

  fscm_clkmux u_mux (
    .clk_int(clk_int), .clk_pri(clk_pri), .rst_n(rst_n), .want_pri(want_pri),
    .clk_sys(clk_sys)
  );
endmodule

// File: tb/tb_fscm_top.sv
`timescale 1ns/1ps
module tb_fscm_top;
  localparam int DIV = 64;
  localparam int WIN = 480;

  logic clk_int = 1'b0, clk_pri = 1'b0, rst_n = 1'b0;
  logic mon_en = 1'b1, osc_ready = 1'b0, pm_entry = 1'b0;
  logic clk_sys, fail_irq, wdt_rst, pri_ready;

  bit pri_run = 1'b1;
  bit pri_hold = 1'b0;
  int pri_half = 6;
  int checks = 0, errors = 0;
  int sys_cnt = 0, pri_cnt = 0, wdt_hi = 0, wdt_pulses = 0, cyc = 0;
  bit wdt_prev = 1'b0;
  bit done = 1'b0;

  fscm_top #(.DIV(DIV)) dut (
    .clk_int(clk_int), .clk_pri(clk_pri), .rst_n(rst_n), .mon_en(mon_en),
    .osc_ready(osc_ready), .pm_entry(pm_entry), .clk_sys(clk_sys),
    .fail_irq(fail_irq), .wdt_rst(wdt_rst), .pri_ready(pri_ready)
  );

  always #2 clk_int = ~clk_int;

  always begin
    if (pri_run) #(pri_half) clk_pri = ~clk_pri;
    else begin #1 clk_pri = pri_hold; end
  end

  always @(posedge clk_sys) sys_cnt++;
  always @(posedge clk_pri) pri_cnt++;

  always @(posedge clk_int) begin
    #1;
    cyc++;
    if (wdt_rst) begin
      wdt_hi++;
      if (!wdt_prev) wdt_pulses++;
    end
    wdt_prev = wdt_rst;
  end

  function automatic int exp_int_edges(int win_ns);
    return win_ns / 4;
  endfunction

  function automatic bit near(int a, int b, int tol);
    return (a >= b - tol) && (a <= b + tol);
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk_int);
    #1;
  endtask

  task automatic measure(output int sd, output int pd);
    int s0, p0;
    s0 = sys_cnt; p0 = pri_cnt;
    #(WIN);
    sd = sys_cnt - s0; pd = pri_cnt - p0;
  endtask

  task automatic on_internal(string tag);
    int sd, pd;
    measure(sd, pd);
    check(near(sd, exp_int_edges(WIN), 2), tag, sd, exp_int_edges(WIN));
  endtask

  task automatic on_primary(string tag);
    int sd, pd;
    measure(sd, pd);
    check(near(sd, pd, 1) && pd > 0, tag, sd, pd);
  endtask

  task automatic stop_pri(bit lvl);
    pri_hold = lvl;
    pri_run = 1'b0;
  endtask

  task automatic start_pri();
    pri_run = 1'b1;
  endtask

  task automatic wait_fail(output int lat);
    lat = 0;
    while (!fail_irq && lat < 1000) begin
      tick(1);
      lat++;
    end
  endtask

  initial begin
    while (!done && cyc < 150000) @(posedge clk_int);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int lat;
    int w0;
    void'($urandom(32'd1234));
    tick(5);
    rst_n = 1'b1;
    tick(2);
    // R1 reset state
    check(pri_ready == 1'b0, "R1 pri_ready", int'(pri_ready), 0);
    check(fail_irq == 1'b0, "R1 fail_irq", int'(fail_irq), 0);
    check(wdt_rst == 1'b0, "R1 wdt_rst", int'(wdt_rst), 0);
    on_internal("R1 clk_sys on internal");

    // R3 no ready: stays on internal, no failure with primary stopped
    stop_pri(1'b0);
    tick(4 * DIV);
    check(fail_irq == 1'b0, "R3 no failure in boot", int'(fail_irq), 0);
    check(pri_ready == 1'b0, "R3 still not ready", int'(pri_ready), 0);
    on_internal("R3 clk_sys internal in boot");
    start_pri();
    tick(20);

    // R2 handover
    osc_ready = 1'b1;
    tick(8);
    check(pri_ready == 1'b1, "R2 pri_ready set", int'(pri_ready), 1);
    tick(40);
    on_primary("R2 clk_sys on primary");

    // R4 random running primary periods, no false alarm
    for (int i = 0; i < 8; i++) begin
      pri_half = 5 + int'($urandom_range(0, 6));
      tick(40);
      on_primary("R4 random period follows primary");
      tick(int'($urandom_range(2 * DIV, 6 * DIV)));
      check(fail_irq == 1'b0, "R4 no false failure", int'(fail_irq), 0);
    end
    pri_half = 6;

    // R5 monitoring disabled
    mon_en = 1'b0;
    tick(3);
    stop_pri(1'b0);
    tick(6 * DIV);
    check(fail_irq == 1'b0, "R5 no detect when disabled", int'(fail_irq), 0);
    check(wdt_pulses == 0, "R5 no wdt pulse", wdt_pulses, 0);
    start_pri();
    tick(20);
    mon_en = 1'b1;
    tick(3 * DIV);
    check(fail_irq == 1'b0, "R5 re-enabled no false failure", int'(fail_irq), 0);

    // R4 R6 R7 R8 stuck-high failure
    stop_pri(1'b1);
    wait_fail(lat);
    check(lat <= fscm_pkg::fail_bound(DIV), "R4 detection latency", lat, fscm_pkg::fail_bound(DIV));
    check(fail_irq == 1'b1, "R6 fail_irq set", int'(fail_irq), 1);
    tick(4);
    check(wdt_pulses == 1, "R7 one wdt pulse", wdt_pulses, 1);
    check(wdt_hi == 1, "R7 pulse one cycle wide", wdt_hi, 1);
    check(pri_ready == 1'b1, "R8 ready kept in fail-safe", int'(pri_ready), 1);
    tick(10);
    on_internal("R6 clk_sys internal with primary stuck high");
    tick(4 * DIV);
    check(fail_irq == 1'b1, "R6 fail_irq sticky", int'(fail_irq), 1);
    check(wdt_pulses == 1, "R7 no extra pulse", wdt_pulses, 1);

    // R9 primary restart does not end fail-safe
    start_pri();
    tick(60);
    on_internal("R9 stays internal after restart");
    check(pri_ready == 1'b1, "R9 ready unchanged", int'(pri_ready), 1);

    // R9 R11 power-mode entry
    osc_ready = 1'b0;
    tick(6);
    pm_entry = 1'b1;
    tick(1);
    pm_entry = 1'b0;
    tick(4);
    check(pri_ready == 1'b0, "R9 pm_entry clears ready", int'(pri_ready), 0);
    check(fail_irq == 1'b1, "R11 fail_irq kept over pm_entry", int'(fail_irq), 1);
    on_internal("R9 back on internal in boot");
    osc_ready = 1'b1;
    tick(8);
    check(pri_ready == 1'b1, "R9 ready again", int'(pri_ready), 1);
    tick(40);
    on_primary("R9 primary after restart");
    w0 = wdt_pulses;
    stop_pri(1'b0);
    tick(fscm_pkg::fail_bound(DIV) + 4);
    check(wdt_pulses == w0 + 1, "R9 monitoring resumed", wdt_pulses, w0 + 1);
    on_internal("R6 internal after stuck-low failure");

    // R11 reset clears the flag
    rst_n = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(2);
    check(fail_irq == 1'b0, "R11 reset clears fail_irq", int'(fail_irq), 0);
    check(pri_ready == 1'b0, "R1 ready cleared by reset", int'(pri_ready), 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule